// File: doc/BRIEF.md
# Three-Stage Compressor Tree Multiplier

This block multiplies two unsigned 8-bit operands and returns the full 16-bit product. An array of AND gates forms the eight partial-product rows. Rows 0 to 3 and rows 4 to 7 are compressed as two independent groups. Each group collapses into one sum row and one carry row. The four rows that result are compressed again, in the same way, into a single sum/carry pair. A ripple carry-propagate adder then merges that pair into the product.

Each column of a compression group gets a cell sized to the number of bits it holds: a plain wire, a half adder, a full adder, or a 4:2 compressor. The 4:2 compressor is two full adders in series. The first adder's carry leaves sideways into the next column as one of that column's inputs. The second adder produces the column's sum bit and its carry bit. A parameter selects whether the product is registered on the rising clock edge (the default) or left purely combinational.

Top module: `wtm_mult`

## Requirements
- R1: With the output register enabled, `p_o` equals the exact unsigned product of the `a_i` and `b_i` values present at the previous rising edge, for all 65536 operand pairs.
- R2: The corner operands give exact results: 255×255 gives 65025, any operand of 0 gives 0, and 1×x gives x.
- R3: The first stage reduces rows 0–3 and rows 4–7 separately. Each group yields a sum/carry row pair whose total equals its four rows. Operands that use only the low or only the high half of `b_i` still produce exact products.
- R4: The second stage reduces the four rows from the first stage to one sum/carry pair with the same total. Operands that fill both halves of `b_i` produce exact products.
- R5: The third stage is a ripple adder whose output equals the sum and carry rows of the second stage added together. Products with long carry runs come out exact.
- R6: While `rst_n` is low, `p_o` is 0. It clears without waiting for a clock edge, and it stays 0 for as long as reset is held.
- R7: `p_o` changes only at a rising clock edge. A change on `a_i` or `b_i` between edges leaves `p_o` unchanged until the next edge.
- R8: A multiplier of `b_i` = 2^k, for every k from 0 to 7, yields `a_i` shifted left by k bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | 8 | Multiplicand, unsigned |
| b_i | input | 8 | Multiplier, unsigned; bit r selects partial-product row r |
| p_o | output | 16 | Unsigned product |

## Verification
With the default register, each product is due at the first rising edge after its operands settle. The bench therefore drives operands on a falling edge and samples `p_o` on the next falling edge. The exhaustive sweep overlaps these steps: at each falling edge it first checks the previous pair and then drives the next one. The hold check samples a quarter period after a mid-cycle operand change, before any edge, and expects the old product. Reset clearing is sampled a few nanoseconds after `rst_n` falls, with no edge in between.

// File: rtl/wtm_pkg.sv
`timescale 1ns/1ps
package wtm_pkg;

    localparam int MAX_COLS = 32;

    typedef logic [MAX_COLS-1:0] col_mask_t;
    typedef col_mask_t [3:0]     grp_mask_t;

    typedef enum logic [2:0] {
        CELL_NONE,
        CELL_WIRE,
        CELL_HA,
        CELL_FA,
        CELL_C42
    } cell_kind_t;

    // Number of rows that may carry a nonzero bit in column c.
    function automatic int col_live(grp_mask_t m, int c);
        int n;
        n = 0;
        for (int r = 0; r < 4; r++) begin
            n += int'(m[r[1:0]][c[4:0]]);
        end
        return n;
    endfunction

    // True when column c is served by a 4:2 compressor.
    // A compressor pushes one lateral bit into the next column.
    function automatic bit col_is42(grp_mask_t m, int c);
        bit lat;
        int t;
        lat = 1'b0;
        for (int k = 0; k <= c; k++) begin
            t   = col_live(m, k) + int'(lat);
            lat = (t >= 4);
        end
        return lat;
    endfunction

    // Live bits in a column, counting the lateral bit from the column below.
    function automatic int col_total(grp_mask_t m, int c);
        int lat;
        lat = (c > 0 && col_is42(m, c - 1)) ? 1 : 0;
        return col_live(m, c) + lat;
    endfunction

    function automatic cell_kind_t col_kind(grp_mask_t m, int c);
        int t;
        t = col_total(m, c);
        if (t >= 4)      return CELL_C42;
        else if (t == 3) return CELL_FA;
        else if (t == 2) return CELL_HA;
        else if (t == 1) return CELL_WIRE;
        else             return CELL_NONE;
    endfunction

    // Source slot k of column c: 0..3 a row, 4 the lateral bit, 5 zero.
    function automatic int col_src(grp_mask_t m, int c, int k);
        int n;
        n = 0;
        for (int r = 0; r < 4; r++) begin
            if (m[r[1:0]][c[4:0]]) begin
                if (n == k) return r;
                n++;
            end
        end
        if (c > 0 && col_is42(m, c - 1) && n == k) return 4;
        return 5;
    endfunction

    function automatic col_mask_t sum_mask(grp_mask_t m, int ncols);
        col_mask_t s;
        s = '0;
        for (int c = 0; c < ncols; c++) begin
            s[c[4:0]] = (col_total(m, c) >= 1);
        end
        return s;
    endfunction

    function automatic col_mask_t carry_mask(grp_mask_t m, int ncols);
        col_mask_t s;
        s = '0;
        for (int c = 0; c + 1 < ncols; c++) begin
            s[5'(c + 1)] = (col_total(m, c) >= 2);
        end
        return s;
    endfunction

    function automatic col_mask_t pp_row_mask(int w, int r);
        col_mask_t s;
        s = '0;
        for (int k = 0; k < w; k++) begin
            s[5'(k + r)] = 1'b1;
        end
        return s;
    endfunction

    function automatic grp_mask_t grp_a_mask(int w, int g);
        grp_mask_t m;
        for (int r = 0; r < 4; r++) begin
            m[r[1:0]] = pp_row_mask(w, 4 * g + r);
        end
        return m;
    endfunction

    function automatic grp_mask_t grp_b_mask(int w);
        grp_mask_t m;
        grp_mask_t a0;
        grp_mask_t a1;
        a0   = grp_a_mask(w, 0);
        a1   = grp_a_mask(w, 1);
        m[0] = sum_mask(a0, 2 * w);
        m[1] = carry_mask(a0, 2 * w);
        m[2] = sum_mask(a1, 2 * w);
        m[3] = carry_mask(a1, 2 * w);
        return m;
    endfunction

endpackage

// File: rtl/wtm_fa.sv
`timescale 1ns/1ps
module wtm_fa (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic axb;

    assign axb = a_i ^ b_i;
    assign s_o = axb ^ c_i;
    assign c_o = (a_i & b_i) | (axb & c_i);
endmodule

// File: rtl/wtm_c42.sv
`timescale 1ns/1ps
// 4:2 compressor: two full adders in series.
// x0+x1+x2+x3+cin = sum + 2*(carry + cout); cout never depends on cin.
module wtm_c42 (
    input  logic x0_i,
    input  logic x1_i,
    input  logic x2_i,
    input  logic x3_i,
    input  logic cin_i,
    output logic sum_o,
    output logic carry_o,
    output logic cout_o
);
    logic mid_s;

    wtm_fa u_first (
        .a_i(x0_i), .b_i(x1_i), .c_i(x2_i),
        .s_o(mid_s), .c_o(cout_o)
    );

    wtm_fa u_second (
        .a_i(mid_s), .b_i(x3_i), .c_i(cin_i),
        .s_o(sum_o), .c_o(carry_o)
    );
endmodule

// File: rtl/wtm_group.sv
`timescale 1ns/1ps
// Compresses four rows into one sum row and one carry row.
// LIVE marks which bits of each row may be nonzero; every column gets a cell
// sized to its live bit count (plus the lateral bit from a compressor below).
module wtm_group
    import wtm_pkg::*;
#(
    parameter int        NCOLS = 16,
    parameter grp_mask_t LIVE  = '0
) (
    input  logic [3:0][NCOLS-1:0] rows_i,
    output logic [NCOLS-1:0]      sum_o,
    output logic [NCOLS-1:0]      carry_o
);
    logic [NCOLS:0] lat_w;
    logic [NCOLS:0] cy_w;
    logic           unused_edge;
    logic           unused_rows;

    assign lat_w[0]    = 1'b0;
    assign cy_w[0]     = 1'b0;
    assign carry_o     = cy_w[NCOLS-1:0];
    assign unused_edge = lat_w[NCOLS] ^ cy_w[NCOLS];
    assign unused_rows = ^rows_i;

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        localparam cell_kind_t KIND = col_kind(LIVE, c);

        logic [4:0] bits;
        logic       unused_col;

        assign unused_col = ^bits;

        for (genvar k = 0; k < 5; k++) begin : g_slot
            localparam int SRC = col_src(LIVE, c, k);
            if (SRC < 4) begin : g_row
                assign bits[k] = rows_i[SRC][c];
            end else if (SRC == 4) begin : g_lat
                assign bits[k] = lat_w[c];
            end else begin : g_zero
                assign bits[k] = 1'b0;
            end
        end

        case (KIND)
            CELL_C42: begin : g_c42
                wtm_c42 u_c42 (
                    .x0_i(bits[0]), .x1_i(bits[1]), .x2_i(bits[2]),
                    .x3_i(bits[3]), .cin_i(bits[4]),
                    .sum_o(sum_o[c]), .carry_o(cy_w[c+1]), .cout_o(lat_w[c+1])
                );
            end
            CELL_FA: begin : g_fa
                wtm_fa u_fa (
                    .a_i(bits[0]), .b_i(bits[1]), .c_i(bits[2]),
                    .s_o(sum_o[c]), .c_o(cy_w[c+1])
                );
                assign lat_w[c+1] = 1'b0;
            end
            CELL_HA: begin : g_ha
                assign sum_o[c]   = bits[0] ^ bits[1];
                assign cy_w[c+1]  = bits[0] & bits[1];
                assign lat_w[c+1] = 1'b0;
            end
            CELL_WIRE: begin : g_wire
                assign sum_o[c]   = bits[0];
                assign cy_w[c+1]  = 1'b0;
                assign lat_w[c+1] = 1'b0;
            end
            default: begin : g_none
                assign sum_o[c]   = 1'b0;
                assign cy_w[c+1]  = 1'b0;
                assign lat_w[c+1] = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wtm_rca.sv
`timescale 1ns/1ps
module wtm_rca #(
    parameter int N = 16
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] s_o
);
    logic [N:0] cy;
    logic       unused_cout;

    assign cy[0]       = 1'b0;
    assign unused_cout = cy[N];

    for (genvar i = 0; i < N; i++) begin : g_bit
        wtm_fa u_fa (
            .a_i(a_i[i]), .b_i(b_i[i]), .c_i(cy[i]),
            .s_o(s_o[i]), .c_o(cy[i+1])
        );
    end
endmodule

// File: rtl/wtm_mult.sv
`timescale 1ns/1ps
// Unsigned multiplier: AND array, two four-row groups, one regroup stage,
// ripple carry-propagate adder. The tree is laid out for OP_W = 8.
module wtm_mult
    import wtm_pkg::*;
#(
    parameter int OP_W    = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    output logic [2*OP_W-1:0] p_o
);
    localparam int PROD_W = 2 * OP_W;
    localparam int GROUPS = OP_W / 4;

    typedef struct packed {
        logic [PROD_W-1:0] prod;
    } out_t;

    logic [PROD_W-1:0] pp [OP_W];
    logic [PROD_W-1:0] sa [GROUPS];
    logic [PROD_W-1:0] ca [GROUPS];
    logic [PROD_W-1:0] sb;
    logic [PROD_W-1:0] cb;
    logic [PROD_W-1:0] fin;
    out_t              out_d;
    out_t              out_q;

    // Partial products: row r is a_i gated by b_i[r], placed at weight r.
    for (genvar r = 0; r < OP_W; r++) begin : g_pp
        assign pp[r] = PROD_W'({OP_W{b_i[r]}} & a_i) << r;
    end

    // First stage: each group of four adjacent rows.
    for (genvar g = 0; g < GROUPS; g++) begin : g_stage_a
        logic [3:0][PROD_W-1:0] rows;
        for (genvar k = 0; k < 4; k++) begin : g_row
            assign rows[k] = pp[4*g+k];
        end
        wtm_group #(
            .NCOLS(PROD_W),
            .LIVE (grp_a_mask(OP_W, g))
        ) u_grp (
            .rows_i (rows),
            .sum_o  (sa[g]),
            .carry_o(ca[g])
        );
    end

    // Second stage: regroup the four rows from the first stage.
    logic [3:0][PROD_W-1:0] rows_b;
    assign rows_b[0] = sa[0];
    assign rows_b[1] = ca[0];
    assign rows_b[2] = sa[1];
    assign rows_b[3] = ca[1];

    wtm_group #(
        .NCOLS(PROD_W),
        .LIVE (grp_b_mask(OP_W))
    ) u_stage_b (
        .rows_i (rows_b),
        .sum_o  (sb),
        .carry_o(cb)
    );

    // Third stage: carry-propagate merge.
    wtm_rca #(.N(PROD_W)) u_stage_c (
        .a_i(sb),
        .b_i(cb),
        .s_o(fin)
    );

    always_comb begin
        out_d      = out_q;
        out_d.prod = fin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    if (REG_OUT) begin : g_reg
        assign p_o = out_q.prod;
    end else begin : g_comb
        assign p_o = fin;
    end

    // Assertions
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r3_stage_a_total: assert property (@(posedge clk) disable iff (!rst_n)
        (PROD_W'(sa[0] + ca[0]) == PROD_W'(pp[0] + pp[1] + pp[2] + pp[3])) &&
        (PROD_W'(sa[1] + ca[1]) == PROD_W'(pp[4] + pp[5] + pp[6] + pp[7])));

    a_r4_stage_b_total: assert property (@(posedge clk) disable iff (!rst_n)
        PROD_W'(sb + cb) == PROD_W'(sa[0] + ca[0] + sa[1] + ca[1]));

    a_r5_cpa_total: assert property (@(posedge clk) disable iff (!rst_n)
        fin == PROD_W'(sb + cb));

    if (REG_OUT) begin : g_chk_reg
        a_r1_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q |-> (p_o == PROD_W'(PROD_W'($past(a_i)) * PROD_W'($past(b_i)))));
    end else begin : g_chk_comb
        a_r1_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
            p_o == PROD_W'(PROD_W'(a_i) * PROD_W'(b_i)));
    end
endmodule

// File: tb/wtm_mult_test.sv
`timescale 1ns/1ps
module wtm_mult_test;
    logic        clk;
    logic        rst_n;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] p;
    int          n_run;
    int          n_fail;
    bit          done;

    wtm_mult #(.OP_W(8), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .p_o(p)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_mul(input int x, input int y);
        return (x * y) & 16'hFFFF;
    endfunction

    task automatic apply(input string req, input int x, input int y);
        @(negedge clk);
        a = 8'(x);
        b = 8'(y);
        @(negedge clk);
        check(req, $sformatf("%0d*%0d", x, y), int'(p), ref_mul(x, y));
    endtask

    task automatic t_reset;
        a     = 8'd200;
        b     = 8'd177;
        rst_n = 1'b1;
        #1 rst_n = 1'b0;
        #2 check("R6", "output during reset", int'(p), 0);
        repeat (3) @(negedge clk);
        check("R6", "output held in reset", int'(p), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_corners;
        apply("R2", 255, 255);
        apply("R2", 0, 255);
        apply("R2", 255, 0);
        apply("R2", 1, 173);
        apply("R2", 94, 1);
    endtask

    task automatic t_groups;
        apply("R3", 255, 15);
        apply("R3", 171, 9);
        apply("R3", 255, 240);
        apply("R3", 77, 160);
        apply("R4", 255, 165);
        apply("R4", 219, 129);
        apply("R4", 170, 85);
    endtask

    task automatic t_shift;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            a = 8'd213;
            b = 8'(1 << k);
            @(negedge clk);
            check("R8", $sformatf("shift by %0d", k), int'(p), 213 << k);
        end
    endtask

    task automatic t_hold;
        @(negedge clk);
        a = 8'd3;
        b = 8'd5;
        @(negedge clk);
        check("R7", "first product", int'(p), 15);
        a = 8'd7;
        b = 8'd9;
        #5 check("R7", "held between edges", int'(p), 15);
        @(negedge clk);
        check("R7", "updated after edge", int'(p), 63);
    endtask

    task automatic t_reset_mid;
        apply("R6", 200, 200);
        #2 rst_n = 1'b0;
        #2 check("R6", "async clear", int'(p), 0);
        @(negedge clk);
        check("R6", "clear held", int'(p), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6", "first product after release", int'(p), 40000);
    endtask

    task automatic t_sweep;
        int pa;
        int pb;
        bit have;
        have = 1'b0;
        pa   = 0;
        pb   = 0;
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                @(negedge clk);
                if (have) check("R1,R5", $sformatf("%0d*%0d", pa, pb), int'(p), ref_mul(pa, pb));
                a    = 8'(ia);
                b    = 8'(ib);
                pa   = ia;
                pb   = ib;
                have = 1'b1;
            end
        end
        @(negedge clk);
        check("R1,R5", $sformatf("%0d*%0d", pa, pb), int'(p), ref_mul(pa, pb));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #3000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        n_run  = 0;
        n_fail = 0;
        done   = 1'b0;
        a      = 8'd0;
        b      = 8'd0;
        rst_n  = 1'b1;
        t_reset();
        t_corners();
        t_groups();
        t_shift();
        t_hold();
        t_reset_mid();
        t_sweep();
        finish_run();
    end
endmodule